// File: doc/BRIEF.md
# Filtered Timestamp Capture Unit

This block records the value of an external free-running counter at the moment a chosen signal edge arrives. Two raw, asynchronous event lines feed it, and a select bit decides which one is watched. Each line is first brought into the clock domain by a two-stage synchronizer. A direction bit then chooses whether rising or falling transitions count as events. Each accepted event copies the counter into a capture register and raises a sticky event flag. Software clears the flag by writing a one to it. An interrupt request follows the flag whenever interrupts are enabled.

The second event line can optionally pass through a debouncing filter. The filter runs on the undivided system clock. Its output moves only once four consecutive samples agree, so it rejects glitches shorter than four cycles at the cost of a fixed four-cycle extra delay. The filter is never applied to the first line, even if the filter-enable bit is set. Because the edge direction can be flipped between events, the block can measure a pulse's high and low times as well as its period. A flip of the direction bit masks any edge seen in that same cycle.

Top module: `tsc_capture`

## Requirements
- R1: After reset, `cap_value_o` is 0, `flag_o` is 0 and `irq_o` is 0.
- R2: With no filter in the path, a transition on the watched input, driven between clock edges, stores the `count_i` value sampled at the third rising clock edge after the change. That is the edge at which `flag_o` sets.
- R3: `edge_sel_i` = 1 selects rising transitions and `edge_sel_i` = 0 selects falling ones. A transition in the other direction leaves `cap_value_o` and `flag_o` unchanged.
- R4: With `src_sel_i` = 1 and `filt_en_i` = 1, the capture happens four clock cycles later than in R2, at the seventh rising edge after the change. A pulse on `src_b_i` lasting fewer than four cycles is never captured.
- R5: With `src_sel_i` = 0, `filt_en_i` has no effect: a one-cycle pulse on `src_a_i` is captured with the R2 latency.
- R6: `src_sel_i` = 0 watches `src_a_i` and `src_sel_i` = 1 watches `src_b_i`. Activity on the other input changes neither `cap_value_o` nor `flag_o`.
- R7: A new event that arrives while `flag_o` is still set overwrites `cap_value_o` with the new count, and `flag_o` stays 1.
- R8: `flag_clr_i` = 1 at a rising edge clears `flag_o`, unless a capture happens at that same edge; in that case `flag_o` stays 1.
- R9: `irq_o` equals `flag_o` AND `irq_en_i` at all times.
- R10: In a cycle where `edge_sel_i` differs from its value at the previous rising edge, no edge is accepted. A transition that reaches the detector in that cycle is dropped, even if it matches the new direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| count_i | input | CNT_W | Free-running counter value to be captured |
| src_a_i | input | 1 | Raw event input 0 (never filtered) |
| src_b_i | input | 1 | Raw event input 1 (filter allowed) |
| src_sel_i | input | 1 | 0 = watch src_a_i, 1 = watch src_b_i |
| edge_sel_i | input | 1 | 1 = rising edge, 0 = falling edge |
| filt_en_i | input | 1 | Enable the four-sample filter (effective only when src_sel_i = 1) |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the event flag |
| cap_value_o | output | CNT_W | Captured counter value |
| flag_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps all eight combinations of source, filter enable and edge direction. For each one it measures the capture latency exactly, so a filter that adds three or five cycles, or a synchronizer that is one stage short, shows up as a wrong captured count. Filter pulses of one to three cycles must vanish and a four-cycle pulse must get through; an off-by-one in the agreement window would either pass short glitches or swallow the minimum pulse. A one-cycle pulse on the unfiltered input with the filter enabled catches a design that lets the enable reach the wrong source. Further cases cover a flag clear that coincides with a capture (a design that gives the clear priority loses the event), an edge that lands in the cycle the direction flips (a design without the mask captures it), and back-to-back events that must overwrite the register.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_dir_e;

  typedef enum logic {
    SRC_RAW  = 1'b0,
    SRC_FILT = 1'b1
  } src_id_e;

endpackage

// File: rtl/tsc_rst_sync.sv
module tsc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/tsc_sync.sv
module tsc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] stg_q;
    logic [STAGES-1:0] stg_d;

    always_comb begin
      stg_d = {stg_q[STAGES-2:0], d_i[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= stg_d;
    end

    assign q_o[b] = stg_q[STAGES-1];
  end

endmodule

// File: rtl/tsc_filter.sv
module tsc_filter #(
  parameter int TAPS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_i,
  output logic dout_o
);

  localparam int HW = TAPS - 1;

  logic [HW-1:0]   hist_q, hist_d;
  logic [TAPS-1:0] window;
  logic            out_q, out_d;
  logic            all_hi, all_lo;

  assign window = {din_i, hist_q};
  assign all_hi = &window;
  assign all_lo = ~|window;

  always_comb begin
    hist_d = {hist_q[HW-2:0], din_i};
    out_d  = out_q;
    if (all_hi)      out_d = 1'b1;
    else if (all_lo) out_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      out_q  <= 1'b0;
    end else begin
      hist_q <= hist_d;
      out_q  <= out_d;
    end
  end

  assign dout_o = out_q;

  AST_FILT_AGREE_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (&window) |=> dout_o);  // R4
  AST_FILT_AGREE_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (window == '0) |=> !dout_o);  // R4
  AST_FILT_MIXED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&window) && (window != '0)) |=> $stable(dout_o));  // R4

endmodule

// File: rtl/tsc_edge.sv
module tsc_edge
  import tsc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic dir_i,
  output logic hit_o
);

  logic prev_q;
  logic dir_q;
  logic rise, fall, dir_flip;

  assign rise     = level_i & ~prev_q;
  assign fall     = ~level_i & prev_q;
  assign dir_flip = dir_i ^ dir_q;

  always_comb begin
    hit_o = 1'b0;
    if (!dir_flip) hit_o = (edge_dir_e'(dir_i) == EDGE_RISE) ? rise : fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      dir_q  <= 1'b1;
    end else begin
      prev_q <= level_i;
      dir_q  <= dir_i;
    end
  end

  AST_HIT_NEEDS_TRANSITION: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (level_i != prev_q) && (level_i == dir_i));  // R3

endmodule

// File: rtl/tsc_capture.sv
module tsc_capture
  import tsc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic             src_a_i,
  input  logic             src_b_i,
  input  logic             src_sel_i,
  input  logic             edge_sel_i,
  input  logic             filt_en_i,
  input  logic             irq_en_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cap_value_o,
  output logic             flag_o,
  output logic             irq_o
);

  localparam int NSRC = 2;

  logic            rst_s_n;
  logic [NSRC-1:0] raw_s;
  logic            filt_b;
  logic            level;
  logic            hit;
  logic [CNT_W-1:0] cap_q, cap_d;
  logic            flag_q, flag_d;

  tsc_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_s_n)
  );

  tsc_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .d_i   ({src_b_i, src_a_i}),
    .q_o   (raw_s)
  );

  tsc_filter #(.TAPS(FILT_TAPS)) i_filter (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .din_i  (raw_s[1]),
    .dout_o (filt_b)
  );

  // The filter only ever sits on the second source.
  always_comb begin
    if (src_id_e'(src_sel_i) == SRC_FILT) level = filt_en_i ? filt_b : raw_s[1];
    else                                  level = raw_s[0];
  end

  tsc_edge i_edge (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .level_i (level),
    .dir_i   (edge_sel_i),
    .hit_o   (hit)
  );

  always_comb begin
    cap_d  = cap_q;
    flag_d = flag_q;
    if (flag_clr_i) flag_d = 1'b0;
    if (hit) begin
      cap_d  = count_i;
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cap_q  <= cap_d;
      flag_q <= flag_d;
    end
  end

  assign cap_value_o = cap_q;
  assign flag_o      = flag_q;
  assign irq_o       = flag_q & irq_en_i;

  AST_CAP_TAKES_COUNT: assert property (@(posedge clk) disable iff (!rst_s_n)
    hit |=> cap_value_o == $past(count_i));  // R2
  AST_CAP_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    !hit |=> $stable(cap_value_o));  // R3
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_s_n)
    hit |=> flag_o);  // R8
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (flag_clr_i && !hit) |=> !flag_o);  // R8

endmodule

// File: tb/test_tsc_capture.sv
module test_tsc_capture;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CNT_W-1:0] count_i;
  logic             src_a_i, src_b_i, src_sel_i, edge_sel_i, filt_en_i;
  logic             irq_en_i, flag_clr_i;
  logic [CNT_W-1:0] cap_value_o;
  logic             flag_o, irq_o;

  int checks = 0;
  int errors = 0;
  int cnt    = 0;

  always #5ns clk = ~clk;

  tsc_capture #(.CNT_W(CNT_W)) i_tsc_capture (
    .clk         (clk),
    .rst_n       (rst_n),
    .count_i     (count_i),
    .src_a_i     (src_a_i),
    .src_b_i     (src_b_i),
    .src_sel_i   (src_sel_i),
    .edge_sel_i  (edge_sel_i),
    .filt_en_i   (filt_en_i),
    .irq_en_i    (irq_en_i),
    .flag_clr_i  (flag_clr_i),
    .cap_value_o (cap_value_o),
    .flag_o      (flag_o),
    .irq_o       (irq_o)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt++;
      count_i = CNT_W'(cnt);
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_clr();
    flag_clr_i = 1'b1;
    tick();
    flag_clr_i = 1'b0;
  endtask

  task automatic drive_sel(input logic sel, input logic v);
    if (sel) src_b_i = v;
    else     src_a_i = v;
  endtask

  task automatic drive_other(input logic sel, input logic v);
    if (sel) src_a_i = v;
    else     src_b_i = v;
  endtask

  initial begin
    #2_000_000ns;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [CNT_W-1:0] held;
    int t;
    rst_n = 1'b0; count_i = '0; src_a_i = 0; src_b_i = 0; src_sel_i = 0;
    edge_sel_i = 1; filt_en_i = 0; irq_en_i = 0; flag_clr_i = 0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    irq_en_i = 1'b1;
    chk("R1 cap", 32'(cap_value_o), 0);
    chk("R1 flag", 32'(flag_o), 0);
    chk("R1 irq", 32'(irq_o), 0);

    // Sweep every source / filter / direction combination.
    for (int cfg = 0; cfg < 8; cfg++) begin
      logic s, f, e, idle;
      int lat;
      string tag;
      s = cfg[2]; f = cfg[1]; e = cfg[0];
      idle = ~e;
      lat  = (s && f) ? 6 : 2;
      tag  = (s && f) ? "R4" : (f ? "R5" : "R2");
      src_sel_i = s; filt_en_i = f; edge_sel_i = e;
      src_a_i = idle; src_b_i = idle;
      tick(12);
      pulse_clr();
      chk("R8 cleared", 32'(flag_o), 0);
      held = cap_value_o;
      // non-selected input toggles both ways
      drive_other(s, ~idle); tick(5);
      drive_other(s, idle);  tick(10);
      chk("R6 other flag", 32'(flag_o), 0);
      chk("R6 other cap", 32'(cap_value_o), 32'(held));
      // active edge
      t = cnt;
      drive_sel(s, ~idle);
      tick(10);
      chk(tag, 32'(cap_value_o), 32'(CNT_W'(t + lat)));
      chk({tag, " flag"}, 32'(flag_o), 1);
      irq_en_i = 1'b0; tick();
      chk("R9 masked", 32'(irq_o), 0);
      irq_en_i = 1'b1; tick();
      chk("R9 enabled", 32'(irq_o), 1);
      pulse_clr();
      chk("R8 w1c", 32'(flag_o), 0);
      chk("R9 after clear", 32'(irq_o), 0);
      // opposite direction ignored
      held = cap_value_o;
      drive_sel(s, idle);
      tick(10);
      chk("R3 opp flag", 32'(flag_o), 0);
      chk("R3 opp cap", 32'(cap_value_o), 32'(held));
    end

    // Filter: short pulses rejected, four-cycle pulse passes.
    src_sel_i = 1; filt_en_i = 1; edge_sel_i = 1; src_a_i = 0; src_b_i = 0;
    tick(12);
    pulse_clr();
    for (int w = 1; w <= 3; w++) begin
      held = cap_value_o;
      src_b_i = 1; tick(w);
      src_b_i = 0; tick(12);
      chk("R4 glitch flag", 32'(flag_o), 0);
      chk("R4 glitch cap", 32'(cap_value_o), 32'(held));
    end
    t = cnt;
    src_b_i = 1; tick(4);
    src_b_i = 0; tick(12);
    chk("R4 min pulse", 32'(cap_value_o), 32'(CNT_W'(t + 6)));
    chk("R4 min pulse flag", 32'(flag_o), 1);
    pulse_clr();

    // Filter enable ignored on first source: one-cycle pulse captured.
    src_sel_i = 0; tick(12);
    pulse_clr();
    t = cnt;
    src_a_i = 1; tick();
    src_a_i = 0; tick(12);
    chk("R5 short pulse", 32'(cap_value_o), 32'(CNT_W'(t + 2)));
    chk("R5 flag", 32'(flag_o), 1);

    // Overwrite while flag still set.
    filt_en_i = 0;
    tick(3);
    t = cnt;
    src_a_i = 1; tick(2);
    src_a_i = 0; tick(8);
    chk("R7 overwrite", 32'(cap_value_o), 32'(CNT_W'(t + 2)));
    chk("R7 flag kept", 32'(flag_o), 1);

    // Clear and capture at the same edge: capture wins.
    t = cnt;
    src_a_i = 1; tick(2);
    flag_clr_i = 1'b1; tick();
    flag_clr_i = 1'b0;
    chk("R8 collision flag", 32'(flag_o), 1);
    chk("R8 collision cap", 32'(cap_value_o), 32'(CNT_W'(t + 2)));
    src_a_i = 0; tick(10);
    pulse_clr();

    // Direction flip in the cycle the edge reaches the detector.
    edge_sel_i = 0; tick(10);
    pulse_clr();
    held = cap_value_o;
    src_a_i = 1; tick(2);
    edge_sel_i = 1; tick(10);
    chk("R10 masked flag", 32'(flag_o), 0);
    chk("R10 masked cap", 32'(cap_value_o), 32'(held));
    src_a_i = 0; tick(10);
    t = cnt;
    src_a_i = 1; tick(10);
    chk("R10 later edge", 32'(cap_value_o), 32'(CNT_W'(t + 2)));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule